// File: doc/BRIEF.md
# Digital DC Offset Correction Loop

This block removes a slowly varying DC offset from a stream of 14-bit offset-binary converter samples. While it is enabled, a first-order loop accumulates how far each corrected sample lies from a target level. It then subtracts the resulting estimate from every incoming sample. The target is midcode plus a small signed pedestal, so the corrected stream settles with its average at that level.

The loop bandwidth is set by a 4-bit time-constant code. Each step of the code doubles the time constant, starting at 2^20 sample clocks. The estimate can be frozen: estimation stops, but the last estimate is still applied to every sample. When the enable is low, the samples pass through unchanged and the estimate is cleared. A parameter lowers the base exponent, so a short simulation can show the full settling behaviour.

Top module: `dc_offset_corr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sample_out` becomes 0 and the internal estimate becomes 0.
- R2: While `corr_en` is low, `sample_out` equals the `sample_in` value of the previous clock edge, through exactly one register.
- R3: A cycle with `corr_en` low clears the estimate. In the first enabled cycle after it, the output equals the input.
- R4: While enabled and not frozen, the accumulator adds (previous `sample_out` − target) × 2^(SHIFT_MAX − s) every cycle. The estimate is the accumulator divided by 2^SHIFT_MAX, rounded toward minus infinity, and the output is `sample_in` minus the estimate.
- R5: For a constant input, the output converges exactly to target = 2^(DW−1) + pedestal. Here `pedestal` is a 6-bit two's-complement value from −32 to +31.
- R6: A time-constant code n in 0..11 selects a loop shift s = TC_BASE + n. A larger code makes the loop settle more slowly.
- R7: Codes 12 to 15 behave exactly like code 11.
- R8: While `freeze` is high and `corr_en` is high, the estimate is held. The output is then the input minus the held estimate.
- R9: The corrected result saturates: below 0 it gives 0, and above 2^DW − 1 it gives 2^DW − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| corr_en | input | 1 | Enables offset correction |
| freeze | input | 1 | Holds the current estimate |
| tc_code | input | 4 | Loop time-constant code |
| pedestal | input | 6 | Signed settling offset around midcode |
| sample_in | input | 14 | Offset-binary input sample |
| sample_out | output | 14 | Corrected offset-binary sample |

## Verification
The bench first holds the input at a constant offset above midcode, once with a zero pedestal and once with each extreme pedestal. These runs show whether the loop settles on the exact target or on some other level. A step input is then run under two time-constant codes, which shows whether the code really scales the settling speed. The same step under code 11 and under a reserved code shows whether reserved codes map onto the slowest setting. Finally, a frozen estimate is combined with inputs that jump far away, including values near both ends of the code range. This separates hold behaviour from tracking and shows whether the result saturates rather than wraps.

// File: rtl/dcoc_pkg.sv
// Shared types for the DC offset correction loop.
// Assumes: one loop-mode decode is shared by the top module and the estimator.
package dcoc_pkg;
    typedef enum logic [1:0] {
        LOOP_OFF   = 2'd0,
        LOOP_TRACK = 2'd1,
        LOOP_HOLD  = 2'd2
    } loop_mode_e;
endpackage

// File: rtl/dcoc_tc_decode.sv
// Maps the time-constant code to the loop shift amount.
// Assumes: codes at or above TC_CODES are reserved and map to the longest setting.
module dcoc_tc_decode #(
    parameter int TC_W     = 4,
    parameter int TC_BASE  = 20,
    parameter int TC_CODES = 12,
    parameter int SH_W     = 5
) (
    input  logic [TC_W-1:0] tc_code,
    output logic [SH_W-1:0] shift
);
    localparam int SHIFT_MAX = TC_BASE + TC_CODES - 1;

    // Select the shift and clamp reserved codes to the maximum.
    always_comb begin
        if (int'(tc_code) >= TC_CODES)
            shift = SH_W'(SHIFT_MAX);
        else
            shift = SH_W'(TC_BASE) + SH_W'(tc_code);
    end
endmodule

// File: rtl/dcoc_estimator.sv
// First-order offset estimator. A fixed-point accumulator with SHIFT_MAX
// fractional bits integrates the error between the corrected output and the target.
// Assumes: out_q is the registered corrected sample, so the loop has one cycle of delay.
module dcoc_estimator
    import dcoc_pkg::*;
#(
    parameter int DW    = 14,
    parameter int PED_W = 6,
    parameter int FRAC  = 31,
    parameter int INT_W = 16,
    parameter int SH_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  loop_mode_e              mode,
    input  logic [SH_W-1:0]         shift,
    input  logic [PED_W-1:0]        pedestal,
    input  logic [DW-1:0]           out_q,
    output logic signed [INT_W-1:0] est
);
    localparam int ACC_W = FRAC + INT_W;
    localparam int MID   = 1 << (DW - 1);

    logic signed [ACC_W-1:0] acc;
    logic signed [INT_W-1:0] target;
    logic signed [INT_W-1:0] err;
    logic signed [ACC_W-1:0] err_x;
    logic        [SH_W-1:0]  lsh;

    // Form the target level and the weighted error term.
    always_comb begin
        target = INT_W'(MID) + INT_W'($signed(pedestal));
        err    = $signed({{(INT_W-DW){1'b0}}, out_q}) - target;
        err_x  = {{(ACC_W-INT_W){err[INT_W-1]}}, err};
        lsh    = SH_W'(FRAC) - shift;
    end

    // Integrate the error, hold it, or clear it, depending on the loop mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else begin
            case (mode)
                LOOP_TRACK: acc <= acc + (err_x <<< lsh);
                LOOP_HOLD:  acc <= acc;
                default:    acc <= '0;
            endcase
        end
    end

    // The integer part of the accumulator is the estimate, rounded down.
    assign est = acc[ACC_W-1:FRAC];
endmodule

// File: rtl/dcoc_corrector.sv
// Subtracts the estimate from the input sample, saturates the result and registers it.
// Assumes: the samples are offset binary from 0 to 2^DW-1.
module dcoc_corrector #(
    parameter int DW    = 14,
    parameter int INT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [DW-1:0]           sample_in,
    input  logic signed [INT_W-1:0] est,
    output logic [DW-1:0]           sample_out
);
    localparam int DIFF_W = INT_W + 1;
    localparam int MAXV   = (1 << DW) - 1;

    logic signed [DIFF_W-1:0] diff;
    logic        [DW-1:0]     clamped;

    // Compute the corrected value and clamp it to the code range.
    always_comb begin
        diff = $signed({{(DIFF_W-DW){1'b0}}, sample_in}) - DIFF_W'(est);
        if (diff < 0)
            clamped = '0;
        else if (diff > DIFF_W'(MAXV))
            clamped = DW'(MAXV);
        else
            clamped = diff[DW-1:0];
    end

    // Register either the corrected sample or the raw sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_out <= '0;
        else
            sample_out <= enable ? clamped : sample_in;
    end
endmodule

// File: rtl/dc_offset_corr.sv
// Top level of the digital DC offset correction loop.
// Assumes: the controls are synchronous to clk. The pedestal is two's complement.
module dc_offset_corr
    import dcoc_pkg::*;
#(
    parameter int DW       = 14,
    parameter int PED_W    = 6,
    parameter int TC_W     = 4,
    parameter int TC_BASE  = 20,
    parameter int TC_CODES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             corr_en,
    input  logic             freeze,
    input  logic [TC_W-1:0]  tc_code,
    input  logic [PED_W-1:0] pedestal,
    input  logic [DW-1:0]    sample_in,
    output logic [DW-1:0]    sample_out
);
    localparam int SHIFT_MAX = TC_BASE + TC_CODES - 1;
    localparam int FRAC      = SHIFT_MAX;
    localparam int INT_W     = DW + 2;
    localparam int SH_W      = $clog2(SHIFT_MAX + 1);

    loop_mode_e              mode;
    logic [SH_W-1:0]         shift;
    logic signed [INT_W-1:0] est;

    // Decode the loop mode from the enable and freeze controls.
    always_comb begin
        if (!corr_en)
            mode = LOOP_OFF;
        else if (freeze)
            mode = LOOP_HOLD;
        else
            mode = LOOP_TRACK;
    end

    dcoc_tc_decode #(.TC_W(TC_W), .TC_BASE(TC_BASE), .TC_CODES(TC_CODES), .SH_W(SH_W)) u_tc (
        .tc_code (tc_code),
        .shift   (shift)
    );

    dcoc_estimator #(.DW(DW), .PED_W(PED_W), .FRAC(FRAC), .INT_W(INT_W), .SH_W(SH_W)) u_est (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .shift    (shift),
        .pedestal (pedestal),
        .out_q    (sample_out),
        .est      (est)
    );

    dcoc_corrector #(.DW(DW), .INT_W(INT_W)) u_cor (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (corr_en),
        .sample_in  (sample_in),
        .est        (est),
        .sample_out (sample_out)
    );
endmodule

// File: rtl/dcoc_checker.sv
// Assertion checker for dc_offset_corr. It is attached to the top module with bind.
// Assumes: est and shift are the signals that the estimator and the decoder drive.
module dcoc_checker #(
    parameter int DW        = 14,
    parameter int PED_W     = 6,
    parameter int TC_W      = 4,
    parameter int TC_CODES  = 12,
    parameter int SHIFT_MAX = 31,
    parameter int INT_W     = 16,
    parameter int SH_W      = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    corr_en,
    input logic                    freeze,
    input logic [TC_W-1:0]         tc_code,
    input logic [PED_W-1:0]        pedestal,
    input logic [DW-1:0]           sample_in,
    input logic [DW-1:0]           sample_out,
    input logic signed [INT_W-1:0] est,
    input logic [SH_W-1:0]         shift
);
    localparam int MID  = 1 << (DW - 1);
    localparam int MAXV = (1 << DW) - 1;

    logic signed [INT_W:0]   raw;
    logic signed [INT_W-1:0] tgt;
    logic signed [INT_W-1:0] out_s;

    // Reference quantities used by the properties below.
    always_comb begin
        raw   = $signed({{(INT_W+1-DW){1'b0}}, sample_in}) - (INT_W+1)'(est);
        tgt   = INT_W'(MID) + INT_W'($signed(pedestal));
        out_s = $signed({{(INT_W-DW){1'b0}}, sample_out});
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> (sample_out == '0 && est == '0));

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_en |=> sample_out == $past(sample_in));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_en |=> est == '0);

    p_rest_at_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en && !freeze && out_s == tgt) |=> est == $past(est));

    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tc_code) >= TC_CODES) |-> shift == SH_W'(SHIFT_MAX));

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en && freeze) |=> est == $past(est));

    p_sat_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en && raw > (INT_W+1)'(MAXV)) |=> sample_out == DW'(MAXV));

    p_sat_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en && raw < 0) |=> sample_out == '0);
endmodule

bind dc_offset_corr dcoc_checker #(
    .DW(DW), .PED_W(PED_W), .TC_W(TC_W), .TC_CODES(TC_CODES),
    .SHIFT_MAX(SHIFT_MAX), .INT_W(INT_W), .SH_W(SH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .corr_en(corr_en), .freeze(freeze),
    .tc_code(tc_code), .pedestal(pedestal), .sample_in(sample_in),
    .sample_out(sample_out), .est(est), .shift(shift)
);

// File: tb/sim_dc_offset_corr.sv
// Scoreboard bench for dc_offset_corr, built with a scaled-down time constant.
module sim_dc_offset_corr;
    localparam int DW   = 14;
    localparam int TB   = 2;
    localparam int NTC  = 12;
    localparam int F    = TB + NTC - 1;
    localparam int MID  = 1 << (DW - 1);
    localparam int MAXV = (1 << DW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        corr_en = 1'b0;
    logic        freeze = 1'b0;
    logic [3:0]  tc_code = '0;
    logic [5:0]  pedestal = '0;
    logic [13:0] sample_in = '0;
    logic [13:0] sample_out;

    int     tests = 0;
    int     fails = 0;
    bit     done = 0;
    string  cur_req = "R1";
    longint m_acc = 0;
    longint m_out = 0;
    int     q[$];

    always #2.5 clk = ~clk;

    dc_offset_corr #(.DW(DW), .PED_W(6), .TC_W(4), .TC_BASE(TB), .TC_CODES(NTC)) u0 (
        .clk(clk), .rst_n(rst_n), .corr_en(corr_en), .freeze(freeze),
        .tc_code(tc_code), .pedestal(pedestal), .sample_in(sample_in),
        .sample_out(sample_out)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the value the model expects.
    task automatic step(input bit r, input bit en, input bit fz, input int tc, input int ped, input int x);
        longint est, d, nout, nacc;
        int sh;
        @(negedge clk);
        rst_n = r; corr_en = en; freeze = fz; tc_code = 4'(tc);
        pedestal = 6'(ped); sample_in = 14'(x);
        if (!r) begin
            m_acc = 0; m_out = 0;
        end else begin
            est = m_acc >>> F;
            sh  = TB + ((tc < NTC) ? tc : NTC - 1);
            if (en) begin
                d = longint'(x) - est;
                nout = (d < 0) ? 0 : ((d > MAXV) ? MAXV : d);
            end else begin
                nout = x;
            end
            if (!en)     nacc = 0;
            else if (fz) nacc = m_acc;
            else         nacc = m_acc + (m_out - longint'(MID + ped)) * (longint'(1) << (F - sh));
            m_acc = nacc; m_out = nout;
        end
        q.push_back(int'(m_out));
    endtask

    task automatic run(input int n, input bit en, input bit fz, input int tc, input int ped, input int x);
        for (int i = 0; i < n; i++) step(1'b1, en, fz, tc, ped, x);
    endtask

    // Read the output after the edge that follows the last step.
    task automatic sample_now(output int v);
        @(posedge clk);
        #2;
        v = int'(sample_out);
    endtask

    // Monitor: compare each output with the value at the head of the queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) check({cur_req, " scoreboard"}, int'(sample_out), q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v, a, b;
        // R1: reset state
        cur_req = "R1";
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 0, 0, 1234 + i);
        sample_now(v); check("R1 reset output", v, 0);
        // R2: pass-through with one register of latency
        cur_req = "R2";
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 0, 0, (i * 2111) % (MAXV + 1));
        step(1'b1, 1'b0, 1'b0, 0, 0, 9999);
        sample_now(v); check("R2 pass-through", v, 9999);
        // R4, R5: convergence with a zero pedestal and with both extreme pedestals
        cur_req = "R4";
        run(200, 1'b1, 1'b0, 0, 0, MID + 300);
        sample_now(v); check("R5 settle ped 0", v, MID);
        cur_req = "R5";
        run(200, 1'b1, 1'b0, 0, -32, MID + 300);
        sample_now(v); check("R5 settle ped -32", v, MID - 32);
        run(200, 1'b1, 1'b0, 0, 31, MID - 500);
        sample_now(v); check("R5 settle ped +31", v, MID + 31);
        // R6: a larger code settles more slowly
        cur_req = "R6";
        run(1, 1'b0, 1'b0, 0, 0, MID);
        run(8, 1'b1, 1'b0, 0, 0, MID + 400);
        sample_now(a);
        run(1, 1'b0, 1'b0, 0, 0, MID);
        run(8, 1'b1, 1'b0, 3, 0, MID + 400);
        sample_now(b);
        check("R6 code 3 slower than code 0", int'((b - MID) > (a - MID)), 1);
        // R7: a reserved code behaves like code 11
        cur_req = "R7";
        run(1, 1'b0, 1'b0, 0, 0, MID);
        run(30, 1'b1, 1'b0, 11, 0, MID + 900);
        sample_now(a);
        run(1, 1'b0, 1'b0, 0, 0, MID);
        run(30, 1'b1, 1'b0, 14, 0, MID + 900);
        sample_now(b);
        check("R7 code 14 equals code 11", b, a);
        check("R7 code 11 corrects", int'(a < MID + 900), 1);
        // R8: freeze holds the estimate while the input jumps
        cur_req = "R8";
        run(1, 1'b0, 1'b0, 0, 0, MID);
        run(200, 1'b1, 1'b0, 0, 0, MID + 300);
        run(50, 1'b1, 1'b1, 0, 0, MID + 1000);
        sample_now(v); check("R8 frozen offset", v, MID + 700);
        // R9: saturation at the low end with the held estimate of +300
        cur_req = "R9";
        run(3, 1'b1, 1'b1, 0, 0, 100);
        sample_now(v); check("R9 saturate low", v, 0);
        // R3: disabling clears the estimate
        cur_req = "R3";
        run(1, 1'b0, 1'b0, 0, 0, MID);
        run(1, 1'b1, 1'b0, 0, 0, MID + 555);
        sample_now(v); check("R3 cleared estimate", v, MID + 555);
        // R9: saturation at the high end with an estimate of -300
        cur_req = "R9";
        run(1, 1'b0, 1'b0, 0, 0, MID);
        run(200, 1'b1, 1'b0, 0, 0, MID - 300);
        run(3, 1'b1, 1'b1, 0, 0, MAXV);
        sample_now(v); check("R9 saturate high", v, MAXV);
        run(2, 1'b1, 1'b0, 0, 0, MID);
        repeat (3) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule